// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel left and right samples. It runs directly on the serial bit clock. On every rising edge it samples the frame clock and the data line together. A three-bit format code chooses how the data bits sit relative to the frame-clock transitions. The choices are a word that starts at the transition, a word delayed by one bit period, or a word that ends at the next transition with a length of 16, 18, 20 or 24 bits.

Each finished stereo frame is delivered as two signed 24-bit words. Shorter words are left-aligned and padded with zeros in the low bits. A one-cycle strobe marks the new pair. A format code may be changed at any time, but it takes effect only at a frame boundary, and the frame in progress at that moment is thrown away. The two codes that name no format raise an error flag, and while they are active the last good pair is held.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, both sample outputs are zero, `sample_valid` and `format_error` are low, and the active format is code 000.
- R2: Code 000 (start-aligned): a high frame clock marks the left half. The bit sampled on the same rising edge that first sees the new frame-clock level is the MSB. At most 24 bits per half are kept, later bits are ignored, and a shorter half leaves zeros in the low bits.
- R3: Code 001 (one-bit delay): a low frame clock marks the left half. The MSB is sampled on the second rising edge of the half. Up to 24 bits are kept and the rest are ignored.
- R4: End-aligned codes keep only the last N bits sampled before the next frame-clock change: 010 gives N=16, 011 gives N=24, 100 gives N=20 and 101 gives N=18. The word is placed in the top N bits of the output, with zeros below. For these codes a high frame clock marks the left half.
- R5: Codes 110 and 111 drive `format_error` high from the cycle after they appear on `fmt_sel`, and it goes low a cycle after a legal code returns. While such a code is active, no strobe occurs and both outputs hold their last values.
- R6: `sample_valid` is a one-cycle pulse in the cycle after the rising edge that samples the frame-clock change ending a right half. Both outputs update together on that pulse and at no other time.
- R7: A new `fmt_sel` value is adopted at the next frame-clock change that begins a left half under the active format. The frame that this change completes is discarded. If the old and new formats mark the left half with opposite levels, the following frame is lost as well.
- R8: The frame-clock level seen at the first edge after reset starts no half. A frame whose left half did not begin at an observed frame-clock change produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrclk | input | 1 | Frame clock selecting the channel |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Format code |
| left_out | output | 24 | Left sample, left-aligned, signed |
| right_out | output | 24 | Right sample, left-aligned, signed |
| sample_valid | output | 1 | One-cycle strobe for a new stereo pair |
| format_error | output | 1 | High while a reserved code is selected |

## Verification
Every legal format is driven with random bit patterns at half-frame lengths of 16, 18, 20, 24, 25 and 32 bits. A length is skipped when it is shorter than the format's word. Lengths shorter than 24 bits check the zero padding of the justified formats. Lengths longer than the word check that extra leading bits (end-aligned) or trailing bits (justified) are dropped. The one-bit-delay format at length 25 separates the delay from a plain start-aligned capture. Format switches with the same and with opposite left-channel polarity, runs under both reserved codes, and a reset taken in the middle of a half show which frames must be discarded and that the outputs hold.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

   typedef enum logic [2:0] {
      FMT_START  = 3'b000,
      FMT_DELAY  = 3'b001,
      FMT_END16  = 3'b010,
      FMT_END24  = 3'b011,
      FMT_END20  = 3'b100,
      FMT_END18  = 3'b101,
      FMT_BAD6   = 3'b110,
      FMT_BAD7   = 3'b111
   } fmt_e;

   // code names a real format
   function automatic logic fmt_legal(fmt_e f);
      return !((f == FMT_BAD6) || (f == FMT_BAD7));
   endfunction

   // level of the frame clock that marks the left half
   function automatic logic fmt_left_level(fmt_e f);
      return (f != FMT_DELAY);
   endfunction

   // bit periods between the frame-clock change and the MSB (justified codes)
   function automatic logic fmt_msb_delay(fmt_e f);
      return (f == FMT_DELAY);
   endfunction

   // justified word (start or one-bit delay) as opposed to end-aligned
   function automatic logic fmt_justified(fmt_e f);
      return (f == FMT_START) || (f == FMT_DELAY);
   endfunction

   // index into the table of end-aligned word lengths
   function automatic logic [1:0] fmt_end_sel(fmt_e f);
      case (f)
         FMT_END16: return 2'd0;
         FMT_END18: return 2'd1;
         FMT_END20: return 2'd2;
         default:   return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/sarx_frame_track.sv
module sarx_frame_track #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lrclk,
   output logic             frame_edge,
   output logic             prev_level,
   output logic             edge_seen,
   output logic [CNT_W-1:0] bit_idx
);

   localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};

   logic             primed_q;
   logic             lr_q;
   logic             seen_q;
   logic [CNT_W-1:0] cnt_q;

   // the first sample after reset only loads the level history
   assign frame_edge = primed_q && (lrclk != lr_q);
   assign prev_level = lr_q;
   assign edge_seen  = seen_q;
   assign bit_idx    = frame_edge ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         lr_q     <= 1'b0;
         seen_q   <= 1'b0;
         cnt_q    <= IDX_MAX;
      end else begin
         primed_q <= 1'b1;
         lr_q     <= lrclk;
         if (frame_edge) begin
            seen_q <= 1'b1;
         end
         if (bit_idx != IDX_MAX) begin
            cnt_q <= bit_idx + 1'b1;
         end else begin
            cnt_q <= IDX_MAX;
         end
      end
   end

endmodule

// File: rtl/sarx_capture.sv
module sarx_capture
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sdata,
   input  logic                frame_edge,
   input  logic [CNT_W-1:0]    bit_idx,
   input  fmt_e                cap_fmt,
   input  fmt_e                word_fmt,
   output logic [SAMPLE_W-1:0] word
);

   localparam int N_END = 4;

   logic [SAMPLE_W-1:0] just_q;
   logic [SAMPLE_W-1:0] just_nxt;
   logic [SAMPLE_W-1:0] just_hit;
   logic [SAMPLE_W-1:0] just_base;
   logic [SAMPLE_W-1:0] shift_q;
   logic [SAMPLE_W-1:0] shift_nxt;
   logic [CNT_W-1:0]    msb_off;
   logic [SAMPLE_W-1:0] end_word [N_END];

   assign msb_off = CNT_W'(fmt_msb_delay(cap_fmt));

   // one comparator per output bit: bit b is taken at its fixed position
   for (genvar b = 0; b < SAMPLE_W; b++) begin : g_slot
      localparam logic [CNT_W-1:0] SLOT = CNT_W'(SAMPLE_W - 1 - b);
      assign just_hit[b] = (bit_idx == SLOT + msb_off);
   end

   assign just_base = frame_edge ? '0 : just_q;
   assign just_nxt  = (just_base & ~just_hit) | (just_hit & {SAMPLE_W{sdata}});
   assign shift_nxt = frame_edge ? {{(SAMPLE_W-1){1'b0}}, sdata}
                                 : {shift_q[SAMPLE_W-2:0], sdata};

   // end-aligned alignment variants, one per supported word length
   for (genvar g = 0; g < N_END; g++) begin : g_end
      localparam int LEN = (g == 0) ? 16 : (g == 1) ? 18 : (g == 2) ? 20 : 24;
      assign end_word[g] = SAMPLE_W'(shift_q[LEN-1:0]) << (SAMPLE_W - LEN);
   end

   always_comb begin
      if (fmt_justified(word_fmt)) begin
         word = just_q;
      end else begin
         word = end_word[fmt_end_sel(word_fmt)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         just_q  <= '0;
         shift_q <= '0;
      end else begin
         just_q  <= just_nxt;
         shift_q <= shift_nxt;
      end
   end

endmodule

// File: rtl/sarx_pairing.sv
module sarx_pairing
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_edge,
   input  logic                prev_level,
   input  logic                edge_seen,
   input  logic [2:0]          fmt_sel,
   input  logic [SAMPLE_W-1:0] word,
   output fmt_e                cap_fmt,
   output fmt_e                word_fmt,
   output logic [SAMPLE_W-1:0] left_out,
   output logic [SAMPLE_W-1:0] right_out,
   output logic                sample_valid,
   output logic                format_error
);

   fmt_e                active_q;
   fmt_e                req;
   logic                have_left_q;
   logic [SAMPLE_W-1:0] left_hold_q;
   logic                ended_left;
   logic                boundary;
   logic                commit;

   assign req        = fmt_e'(fmt_sel);
   assign ended_left = (prev_level == fmt_left_level(active_q));
   assign boundary   = frame_edge && !ended_left;
   assign commit     = boundary && have_left_q && (req == active_q) && fmt_legal(active_q);

   // the half beginning at a boundary is captured under the format adopted there
   assign cap_fmt  = boundary ? req : active_q;
   assign word_fmt = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q     <= FMT_START;
         have_left_q  <= 1'b0;
         left_hold_q  <= '0;
         left_out     <= '0;
         right_out    <= '0;
         sample_valid <= 1'b0;
         format_error <= 1'b0;
      end else begin
         sample_valid <= commit;
         format_error <= !fmt_legal(req);
         if (commit) begin
            left_out  <= left_hold_q;
            right_out <= word;
         end
         if (frame_edge) begin
            if (ended_left) begin
               left_hold_q <= word;
               have_left_q <= edge_seen;
            end else begin
               have_left_q <= 1'b0;
               active_q    <= req;
            end
         end
      end
   end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 6
) (
   input  logic                bclk,
   input  logic                rst_n,
   input  logic                lrclk,
   input  logic                sdata,
   input  logic [2:0]          fmt_sel,
   output logic [SAMPLE_W-1:0] left_out,
   output logic [SAMPLE_W-1:0] right_out,
   output logic                sample_valid,
   output logic                format_error
);

   if (SAMPLE_W < 24) begin : g_bad_width
      $error("serial_audio_rx: SAMPLE_W must hold a 24-bit word");
   end
   if ((2 ** CNT_W) - 1 <= SAMPLE_W + 1) begin : g_bad_count
      $error("serial_audio_rx: CNT_W too small for the justified window");
   end

   logic                frame_edge;
   logic                prev_level;
   logic                edge_seen;
   logic [CNT_W-1:0]    bit_idx;
   logic [SAMPLE_W-1:0] word;
   fmt_e                cap_fmt;
   fmt_e                word_fmt;

   sarx_frame_track #(.CNT_W(CNT_W)) u_track (
      .clk        (bclk),
      .rst_n      (rst_n),
      .lrclk      (lrclk),
      .frame_edge (frame_edge),
      .prev_level (prev_level),
      .edge_seen  (edge_seen),
      .bit_idx    (bit_idx)
   );

   sarx_capture #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_capture (
      .clk        (bclk),
      .rst_n      (rst_n),
      .sdata      (sdata),
      .frame_edge (frame_edge),
      .bit_idx    (bit_idx),
      .cap_fmt    (cap_fmt),
      .word_fmt   (word_fmt),
      .word       (word)
   );

   sarx_pairing #(.SAMPLE_W(SAMPLE_W)) u_pairing (
      .clk          (bclk),
      .rst_n        (rst_n),
      .frame_edge   (frame_edge),
      .prev_level   (prev_level),
      .edge_seen    (edge_seen),
      .fmt_sel      (fmt_sel),
      .word         (word),
      .cap_fmt      (cap_fmt),
      .word_fmt     (word_fmt),
      .left_out     (left_out),
      .right_out    (right_out),
      .sample_valid (sample_valid),
      .format_error (format_error)
   );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
   parameter int SAMPLE_W = 24
) (
   input logic                bclk,
   input logic                rst_n,
   input logic [2:0]          fmt_sel,
   input logic [SAMPLE_W-1:0] left_out,
   input logic [SAMPLE_W-1:0] right_out,
   input logic                sample_valid,
   input logic                format_error
);

   localparam logic [SAMPLE_W-1:0] PAD16 = {{16{1'b0}}, {(SAMPLE_W-16){1'b1}}};
   localparam logic [SAMPLE_W-1:0] PAD18 = {{18{1'b0}}, {(SAMPLE_W-18){1'b1}}};
   localparam logic [SAMPLE_W-1:0] PAD20 = {{20{1'b0}}, {(SAMPLE_W-20){1'b1}}};

   AST_VALID_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
      sample_valid |=> !sample_valid); // R6

   AST_OUT_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
      !sample_valid |-> ($stable(left_out) && $stable(right_out))); // R6

   AST_ERR_NO_VALID: assert property (@(posedge bclk) disable iff (!rst_n)
      format_error |-> !sample_valid); // R5

   AST_END16_PAD: assert property (@(posedge bclk) disable iff (!rst_n)
      (sample_valid && ($past(fmt_sel) == 3'b010)) |-> (((left_out | right_out) & PAD16) == '0)); // R4

   AST_END18_PAD: assert property (@(posedge bclk) disable iff (!rst_n)
      (sample_valid && ($past(fmt_sel) == 3'b101)) |-> (((left_out | right_out) & PAD18) == '0)); // R4

   AST_END20_PAD: assert property (@(posedge bclk) disable iff (!rst_n)
      (sample_valid && ($past(fmt_sel) == 3'b100)) |-> (((left_out | right_out) & PAD20) == '0)); // R4

endmodule

bind serial_audio_rx sarx_checker #(.SAMPLE_W(SAMPLE_W)) u_sarx_checker (
   .bclk         (bclk),
   .rst_n        (rst_n),
   .fmt_sel      (fmt_sel),
   .left_out     (left_out),
   .right_out    (right_out),
   .sample_valid (sample_valid),
   .format_error (format_error)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;

   localparam int W = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lrclk = 1'b1;
   logic          sdata = 1'b0;
   logic [2:0]    fmt_sel = 3'b000;
   logic [W-1:0]  left_out;
   logic [W-1:0]  right_out;
   logic          sample_valid;
   logic          format_error;

   int            n_run = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   logic          pend = 1'b0;
   logic [W-1:0]  pend_l, pend_r;
   string         pend_tag = "R2";
   logic [W-1:0]  last_l = '0, last_r = '0;
   string         cur_tag = "R8";

   always #2 clk = ~clk;

   serial_audio_rx uut (
      .bclk(clk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata), .fmt_sel(fmt_sel),
      .left_out(left_out), .right_out(right_out),
      .sample_valid(sample_valid), .format_error(format_error)
   );

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic left_lvl(input logic [2:0] f);
      return (f != 3'b001);
   endfunction

   function automatic int end_len(input logic [2:0] f);
      case (f)
         3'b010: return 16;
         3'b011: return 24;
         3'b100: return 20;
         default: return 18;
      endcase
   endfunction

   function automatic string fmt_tag(input logic [2:0] f);
      if (f == 3'b000) return "R2";
      if (f == 3'b001) return "R3";
      return "R4";
   endfunction

   // bit sent at half position p is pat[63-p]
   function automatic logic [W-1:0] exp_word(input logic [2:0] f, input logic [63:0] pat, input int h);
      logic [W-1:0] r = '0;
      int start, n;
      if (f == 3'b000) begin start = 0; n = (h < W) ? h : W; end
      else if (f == 3'b001) begin start = 1; n = (h - 1 < W) ? h - 1 : W; end
      else begin n = end_len(f); start = h - n; end
      for (int j = 0; j < n; j++) r[W-1-j] = pat[63-(start+j)];
      return r;
   endfunction

   task automatic drive_half(input logic lev, input logic [63:0] pat, input int h,
                             input logic sw, input logic [2:0] nf);
      for (int p = 0; p < h; p++) begin
         @(negedge clk);
         if (p == 1 && pend) begin
            check({pend_tag, " R6"}, "valid strobe", W'(sample_valid), W'(1));
            check(pend_tag, "left", left_out, pend_l);
            check(pend_tag, "right", right_out, pend_r);
            last_l = pend_l;
            last_r = pend_r;
            pend = 1'b0;
         end else if (sample_valid) begin
            n_run++;
            n_fail++;
            $display("FAIL %s unexpected valid: actual 1 expected 0", cur_tag);
         end
         if (p == 1) begin
            check("R5", "error flag", W'(format_error), W'(fmt_sel[2] & fmt_sel[1]));
         end
         if (p == 0 && sw) fmt_sel = nf;
         lrclk = lev;
         sdata = pat[63-p];
      end
   endtask

   task automatic drive_frame(input logic [2:0] f, input int hl, input int hr,
                              input logic sw, input logic [2:0] nf, input logic expect_out);
      logic [63:0] pl = {$urandom, $urandom};
      logic [63:0] pr = {$urandom, $urandom};
      logic lev = left_lvl(f);
      drive_half(lev, pl, hl, 1'b0, 3'b000);
      drive_half(!lev, pr, hr, sw, nf);
      if (expect_out) begin
         pend = 1'b1;
         pend_l = exp_word(f, pl, hl);
         pend_r = exp_word(f, pr, hr);
         pend_tag = fmt_tag(f);
      end
   endtask

   // R7: the frame carrying the change is lost; one more on a polarity flip
   task automatic switch_to(input logic [2:0] fo, input logic [2:0] fn);
      cur_tag = "R7";
      drive_frame(fo, 24, 24, 1'b1, fn, 1'b0);
      if (left_lvl(fo) != left_lvl(fn)) drive_frame(fn, 24, 24, 1'b0, 3'b000, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int lens [6] = '{16, 18, 20, 24, 25, 32};
      logic [2:0] fmts [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101};
      logic [2:0] prev_f;
      repeat (5) @(negedge clk);
      check("R1", "left reset", left_out, '0);
      check("R1", "right reset", right_out, '0);
      check("R1", "valid reset", W'(sample_valid), '0);
      check("R1", "error reset", W'(format_error), '0);
      rst_n = 1'b1;
      // R8: reset landed mid left half; finish it, then a right half
      cur_tag = "R8";
      drive_half(1'b1, {$urandom, $urandom}, 12, 1'b0, 3'b000);
      drive_half(1'b0, {$urandom, $urandom}, 24, 1'b0, 3'b000);
      prev_f = 3'b000;
      foreach (fmts[i]) begin
         if (fmts[i] != prev_f) switch_to(prev_f, fmts[i]);
         cur_tag = "R6";
         foreach (lens[k]) begin
            if (fmts[i] == 3'b000 || fmts[i] == 3'b001 || lens[k] >= end_len(fmts[i])) begin
               drive_frame(fmts[i], lens[k], lens[k], 1'b0, 3'b000, 1'b1);
               drive_frame(fmts[i], lens[k], 32 - (lens[k] % 8), 1'b0, 3'b000, 1'b1);
            end
         end
         prev_f = fmts[i];
      end
      // R5: reserved codes hold the last pair
      switch_to(prev_f, 3'b110);
      cur_tag = "R5";
      drive_frame(3'b110, 24, 24, 1'b0, 3'b000, 1'b0);
      drive_frame(3'b110, 24, 24, 1'b0, 3'b000, 1'b0);
      switch_to(3'b110, 3'b111);
      cur_tag = "R5";
      drive_frame(3'b111, 24, 24, 1'b0, 3'b000, 1'b0);
      @(negedge clk);
      check("R5", "held left", left_out, last_l);
      check("R5", "held right", right_out, last_r);
      switch_to(3'b111, 3'b001);
      cur_tag = "R6";
      drive_frame(3'b001, 25, 25, 1'b0, 3'b000, 1'b1);
      drive_frame(3'b001, 32, 32, 1'b0, 3'b000, 1'b1);
      drive_half(1'b0, {$urandom, $urandom}, 4, 1'b0, 3'b000);
      check("R6", "no frame left unchecked", W'(pend), '0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule